// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Refresh

This block is a watchdog timer driven by a down-counter. Software reaches it through a small register bus with an address, a write strobe, a read strobe and a data word. To keep the watchdog from firing, software must service it with a two-step key on the kick register. It first writes the arm byte 00h and then the fire byte FFh. The fire byte only counts when the counter is inside a refresh window. That window is set by a start fraction and an end fraction of the timeout.

After a watchdog reset, the configuration register and the action register accept a single write. That write locks both registers. The first valid refresh, which starts the counter, also locks them. The lock clears only on the watchdog's own reset input. The separate system reset leaves the lock and the configuration untouched. The counter can underflow, or a fire byte can land outside the window. Either event produces a one-cycle error pulse and sets a sticky status bit. When enabled, the same pulse also appears as a reset request that the surrounding system can feed back into the watchdog reset.

Top module: `win_wdt`

## Requirements
- R1: After `rst_ni` the registers read as follows. The configuration register (offset 1) reads 33F3h, the action register (offset 2) reads 01h, the status register (offset 3) reads 0, and the counter register (offset 4) reads 0. The counter stays at 0 and does not run until the first valid refresh.
- R2: Only the low byte of a kick-register write (offset 0) is used. A refresh happens when a kick write of 00h is followed by a kick write of FFh, and any number of repeated 00h writes may come before the FFh. A kick write of any other value cancels a pending 00h. An FFh write with no pending 00h does nothing.
- R3: Neither reads of any register nor writes to other registers break a pending 00h, even when they fall between the 00h and the FFh.
- R4: The configuration and action registers take one write in total. That write, or the first valid refresh, sets the lock, which appears in status bit 2, and every later write to either register is ignored.
- R5: Only `rst_ni` clears the lock. It also restores both registers to their reset values. `sys_rst_ni` clears the sticky status bits and any pending 00h, and it leaves the lock, the configuration and the counter unchanged.
- R6: A valid refresh loads the counter with TOUT_BASE << cfg[1:0] and restarts the prescaler. While the counter runs, it decrements once every 4^cfg[5:4] clocks. Status bit 3 shows that it is running.
- R7: Let Q be a quarter of the reload value. A fire byte is accepted when (3 − cfg[9:8])·Q ≤ count ≤ (cfg[13:12] + 1)·Q. This test is made only on the cycle the FFh is written, so a pending 00h written outside the window does not matter. The first refresh, made while the counter is idle, is always accepted.
- R8: A fire byte that lands outside the window causes three things. `err_o` pulses high for one cycle, status bit 1 is set, and the counter keeps counting without a reload.
- R9: A counter tick at count 0 is an underflow. It pulses `err_o` for one cycle, sets status bit 0 and reloads the counter. Two underflows with no refresh between them are therefore (reload + 1) ticks apart.
- R10: `rst_req_o` pulses together with `err_o` only while bit 0 of the action register is 1. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Watchdog reset, asynchronous, active low; the only source that clears the lock |
| sys_rst_ni | input | 1 | System reset, synchronous, active low; clears sticky status and a pending key |
| bus_addr_i | input | ADDR_W | Register offset |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational, zero when no read is made |
| err_o | output | 1 | One-cycle pulse on an underflow or on a refresh outside the window |
| rst_req_o | output | 1 | One-cycle reset request, gated by bit 0 of the action register |

## Verification
The bench goes after the key sequences that look almost valid. These are 23h then FFh, 00h then AAh then FFh, and a 00h cancelled by a system reset. A detector that only looked at the last byte written would start the counter on these. The bench also checks sequences with repeated 00h, or with reads and other-register writes in between. A detector that reset on any bus traffic would refuse these.

The bench refreshes too early and too late, and it places a 00h outside the window with its FFh inside. A design that tested the window on the 00h, or that reloaded on a violation, shows up as the wrong counter value or the wrong count of error pulses.

It also measures the exact spacing between two underflows and the first decrement after a refresh. This catches an off-by-one in the prescaler or in the underflow compare. Finally, it checks that the lock survives a system reset and clears on a watchdog reset. It tests that lock set by a configuration write and separately by a refresh alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // register offsets on the bus
   localparam int unsigned OFS_KICK = 0;
   localparam int unsigned OFS_CFG  = 1;
   localparam int unsigned OFS_ACT  = 2;
   localparam int unsigned OFS_STAT = 3;
   localparam int unsigned OFS_CNT  = 4;

   // configuration field positions (2-bit fields)
   localparam int unsigned CFG_TOUT_LSB   = 0;
   localparam int unsigned CFG_DIV_LSB    = 4;
   localparam int unsigned CFG_WEND_LSB   = 8;
   localparam int unsigned CFG_WSTART_LSB = 12;

   typedef struct packed {
      logic running;
      logic locked;
      logic win_err;
      logic unf_err;
   } wdt_stat_t;

endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq #(
   parameter int unsigned KEY_W    = 8,
   parameter logic [KEY_W-1:0] KEY_ARM  = '0,
   parameter logic [KEY_W-1:0] KEY_FIRE = '1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sys_rst_ni,
   input  logic             kick_we_i,
   input  logic [KEY_W-1:0] kick_data_i,
   output logic             fire_o
);

   logic armed_q;

   // only kick-register writes move the tracker; all other traffic is invisible here
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         armed_q <= 1'b0;
      else if (!sys_rst_ni)
         armed_q <= 1'b0;
      else if (kick_we_i)
         armed_q <= (kick_data_i == KEY_ARM);
   end

   assign fire_o = kick_we_i && armed_q && (kick_data_i == KEY_FIRE);

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ACT_W    = 8,
   parameter logic [DATA_W-1:0] CFG_RST = DATA_W'(16'h33F3),
   parameter logic [ACT_W-1:0]  ACT_RST = ACT_W'(8'h01)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic              act_we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              fire_i,
   output logic [DATA_W-1:0] cfg_o,
   output logic [ACT_W-1:0]  act_o,
   output logic              locked_o
);

   logic [DATA_W-1:0] cfg_q;
   logic [ACT_W-1:0]  act_q;
   logic              lock_q;

   // the lock is reachable only through the watchdog's own reset
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q  <= CFG_RST;
         act_q  <= ACT_RST;
         lock_q <= 1'b0;
      end else begin
         if (!lock_q && cfg_we_i) cfg_q <= wdata_i;
         if (!lock_q && act_we_i) act_q <= wdata_i[ACT_W-1:0];
         if (cfg_we_i || act_we_i || fire_i) lock_q <= 1'b1;
      end
   end

   assign cfg_o    = cfg_q;
   assign act_o    = act_q;
   assign locked_o = lock_q;

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned TOUT_BASE   = 256,
   parameter int unsigned DIV_STEP    = 2,
   parameter bit          PRESCALE_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [1:0]       tout_sel_i,
   input  logic [1:0]       div_sel_i,
   input  logic [1:0]       wstart_sel_i,
   input  logic [1:0]       wend_sel_i,
   input  logic             fire_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] reload_o,
   output logic             running_o,
   output logic             tick_o,
   output logic             win_viol_o,
   output logic             unf_o
);

   localparam int unsigned PRE_W = (DIV_STEP * 3 > 0) ? DIV_STEP * 3 : 1;

   logic [CNT_W-1:0] count_q, reload, quarter, start_th, end_th;
   logic             running_q, in_win, accept, tick, unf;

   // q * n for n in 0..3, shift-and-add only
   function automatic logic [CNT_W-1:0] mul_q(input logic [CNT_W-1:0] q,
                                              input logic [1:0] n);
      case (n)
         2'd0:    mul_q = '0;
         2'd1:    mul_q = q;
         2'd2:    mul_q = q << 1;
         default: mul_q = (q << 1) + q;
      endcase
   endfunction

   always_comb begin
      reload   = CNT_W'(TOUT_BASE) << tout_sel_i;
      quarter  = reload >> 2;
      start_th = mul_q(quarter, wstart_sel_i) + quarter;
      end_th   = mul_q(quarter, 2'd3 - wend_sel_i);
      in_win   = (count_q <= start_th) && (count_q >= end_th);
   end

   assign accept     = fire_i && (!running_q || in_win);
   assign win_viol_o = fire_i && running_q && !in_win;

   generate
      if (PRESCALE_EN) begin : g_pre
         logic [PRE_W-1:0] pre_q, pre_lim;
         int unsigned      shamt;

         always_comb begin
            shamt   = 32'(div_sel_i) * DIV_STEP;
            pre_lim = ~({PRE_W{1'b1}} << shamt);
         end

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)
               pre_q <= '0;
            else if (accept)
               pre_q <= '0;
            else if (running_q)
               pre_q <= (pre_q == pre_lim) ? '0 : pre_q + 1'b1;
         end

         assign tick = running_q && (pre_q == pre_lim);
      end else begin : g_nopre
         logic div_unused;
         assign div_unused = ^div_sel_i;
         assign tick       = running_q;
      end
   endgenerate

   assign unf = tick && (count_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         count_q   <= '0;
         running_q <= 1'b0;
      end else begin
         if (accept) running_q <= 1'b1;
         if (accept || unf)
            count_q <= reload;
         else if (tick)
            count_q <= count_q - 1'b1;
      end
   end

   assign count_o   = count_q;
   assign reload_o  = reload;
   assign running_o = running_q;
   assign tick_o    = tick;
   assign unf_o     = unf;

endmodule

// File: rtl/win_wdt.sv
module win_wdt #(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned KEY_W       = 8,
   parameter int unsigned ACT_W       = 8,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned TOUT_BASE   = 256,
   parameter int unsigned DIV_STEP    = 2,
   parameter bit          PRESCALE_EN = 1'b1,
   parameter logic [DATA_W-1:0] CFG_RST = DATA_W'(16'h33F3),
   parameter logic [ACT_W-1:0]  ACT_RST = ACT_W'(8'h01)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sys_rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic              bus_re_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              err_o,
   output logic              rst_req_o
);
   import wdt_pkg::*;

   localparam int unsigned MAX_RELOAD = TOUT_BASE << 3;

   generate
      if (ADDR_W < 3)              begin : g_chk_addr $error("ADDR_W must be at least 3"); end
      if (DATA_W < 14)             begin : g_chk_data $error("DATA_W too narrow for config fields"); end
      if (KEY_W > DATA_W)          begin : g_chk_key  $error("KEY_W exceeds DATA_W"); end
      if (ACT_W > DATA_W)          begin : g_chk_act  $error("ACT_W exceeds DATA_W"); end
      if (CNT_W > DATA_W)          begin : g_chk_cnt  $error("CNT_W exceeds DATA_W"); end
      if (TOUT_BASE % 4 != 0)      begin : g_chk_q    $error("TOUT_BASE must be a multiple of 4"); end
      if (MAX_RELOAD >= (1 << CNT_W)) begin : g_chk_fit $error("largest reload does not fit CNT_W"); end
   endgenerate

   logic              kick_we, cfg_we, act_we, fire, locked;
   logic [DATA_W-1:0] cfg_q;
   logic [ACT_W-1:0]  act_q;
   logic [CNT_W-1:0]  count, reload;
   logic              running, tick, win_viol, unf;
   logic              unf_st, win_st, err_q, req_q;
   logic              cfg_unused;
   wdt_stat_t         stat;

   assign kick_we = bus_we_i && (bus_addr_i == ADDR_W'(OFS_KICK));
   assign cfg_we  = bus_we_i && (bus_addr_i == ADDR_W'(OFS_CFG));
   assign act_we  = bus_we_i && (bus_addr_i == ADDR_W'(OFS_ACT));

   wdt_key_seq #(.KEY_W(KEY_W)) key_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sys_rst_ni  (sys_rst_ni),
      .kick_we_i   (kick_we),
      .kick_data_i (bus_wdata_i[KEY_W-1:0]),
      .fire_o      (fire)
   );

   wdt_regs #(
      .DATA_W  (DATA_W),
      .ACT_W   (ACT_W),
      .CFG_RST (CFG_RST),
      .ACT_RST (ACT_RST)
   ) regs_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cfg_we_i (cfg_we),
      .act_we_i (act_we),
      .wdata_i  (bus_wdata_i),
      .fire_i   (fire),
      .cfg_o    (cfg_q),
      .act_o    (act_q),
      .locked_o (locked)
   );

   wdt_core #(
      .CNT_W       (CNT_W),
      .TOUT_BASE   (TOUT_BASE),
      .DIV_STEP    (DIV_STEP),
      .PRESCALE_EN (PRESCALE_EN)
   ) core_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .tout_sel_i   (cfg_q[CFG_TOUT_LSB +: 2]),
      .div_sel_i    (cfg_q[CFG_DIV_LSB +: 2]),
      .wstart_sel_i (cfg_q[CFG_WSTART_LSB +: 2]),
      .wend_sel_i   (cfg_q[CFG_WEND_LSB +: 2]),
      .fire_i       (fire),
      .count_o      (count),
      .reload_o     (reload),
      .running_o    (running),
      .tick_o       (tick),
      .win_viol_o   (win_viol),
      .unf_o        (unf)
   );

   assign cfg_unused = ^{cfg_q, act_q};

   // sticky error flags: system reset may clear them
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         unf_st <= 1'b0;
         win_st <= 1'b0;
      end else if (!sys_rst_ni) begin
         unf_st <= 1'b0;
         win_st <= 1'b0;
      end else begin
         if (unf)      unf_st <= 1'b1;
         if (win_viol) win_st <= 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         err_q <= 1'b0;
         req_q <= 1'b0;
      end else begin
         err_q <= unf || win_viol;
         req_q <= (unf || win_viol) && act_q[0];
      end
   end

   assign err_o     = err_q;
   assign rst_req_o = req_q;

   always_comb begin
      stat.running = running;
      stat.locked  = locked;
      stat.win_err = win_st;
      stat.unf_err = unf_st;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_re_i) begin
         case (bus_addr_i)
            ADDR_W'(OFS_CFG):  bus_rdata_o = cfg_q;
            ADDR_W'(OFS_ACT):  bus_rdata_o = DATA_W'(act_q);
            ADDR_W'(OFS_STAT): bus_rdata_o = DATA_W'(stat);
            ADDR_W'(OFS_CNT):  bus_rdata_o = DATA_W'(count);
            default:           bus_rdata_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/win_wdt_chk.sv
module win_wdt_chk #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ACT_W  = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              sys_rst_ni,
   input logic              locked,
   input logic [DATA_W-1:0] cfg_q,
   input logic [ACT_W-1:0]  act_q,
   input logic              running,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  reload,
   input logic              fire,
   input logic              tick,
   input logic              err_o,
   input logic              rst_req_o,
   input logic              unf_st
);

   // R1
   idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !running |-> count == '0);

   // R4
   cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked |=> $stable(cfg_q) && $stable(act_q));

   // R5
   lock_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked |=> locked);

   // R6
   first_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire && !running) |=> running && (count == $past(reload)));

   // R6
   count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count <= reload);

   // R9
   unf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
      (running && tick && count == '0) |=> err_o && unf_st && (count == reload));

   // R10
   req_with_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |-> err_o);

endmodule

bind win_wdt win_wdt_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ACT_W(ACT_W)) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .sys_rst_ni(sys_rst_ni),
   .locked    (locked),
   .cfg_q     (cfg_q),
   .act_q     (act_q),
   .running   (running),
   .count     (count),
   .reload    (reload),
   .fire      (fire),
   .tick      (tick),
   .err_o     (err_o),
   .rst_req_o (rst_req_o),
   .unf_st    (unf_st)
);

// File: tb/win_wdt_tb_top.sv
module win_wdt_tb_top;

   localparam logic [2:0] A_KICK = 3'd0;
   localparam logic [2:0] A_CFG  = 3'd1;
   localparam logic [2:0] A_ACT  = 3'd2;
   localparam logic [2:0] A_STAT = 3'd3;
   localparam logic [2:0] A_CNT  = 3'd4;

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        sys_rst_ni = 1'b1;
   logic [2:0]  addr = '0;
   logic        we = 1'b0;
   logic        re = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        err_o, rst_req_o;

   int checks = 0;
   int fails  = 0;
   int err_cnt = 0;
   int req_cnt = 0;
   bit done = 0;

   always #2 clk = ~clk;

   win_wdt #(.TOUT_BASE(32)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_ni),
      .sys_rst_ni  (sys_rst_ni),
      .bus_addr_i  (addr),
      .bus_we_i    (we),
      .bus_re_i    (re),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .err_o       (err_o),
      .rst_req_o   (rst_req_o)
   );

   always @(posedge clk) begin
      #1;
      if (err_o)     err_cnt++;
      if (rst_req_o) req_cnt++;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
      addr = a; re = 1'b1;
      #1;
      d = rdata;
      re = 1'b0;
   endtask

   task automatic wait_cnt(input logic [15:0] v, input string req);
      logic [15:0] r;
      for (int i = 0; i < 600; i++) begin
         bus_rd(A_CNT, r);
         if (r == v) return;
         @(negedge clk);
      end
      check(req, 32'(r), 32'(v));
   endtask

   task automatic wait_err(input int lim, output int n);
      n = 0;
      while (!err_o && n < lim) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic wd_reset();
      rst_ni = 1'b0;
      @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] r;
      bus_rd(A_CFG, r);  check("R1 cfg reset", 32'(r), 32'h33F3);
      bus_rd(A_ACT, r);  check("R1 act reset", 32'(r), 32'h01);
      bus_rd(A_STAT, r); check("R1 stat reset", 32'(r), 32'h0);
      repeat (10) @(negedge clk);
      bus_rd(A_CNT, r);  check("R1 counter idle", 32'(r), 32'h0);
   endtask

   task automatic t_bad_keys();
      logic [15:0] r;
      bus_wr(A_KICK, 16'h0023); bus_wr(A_KICK, 16'h00FF);
      bus_rd(A_STAT, r); check("R2 23h then FFh no start", 32'(r), 32'h0);
      bus_wr(A_KICK, 16'h0000); bus_wr(A_KICK, 16'h00AA); bus_wr(A_KICK, 16'h00FF);
      bus_rd(A_STAT, r); check("R2 00h AAh FFh no start", 32'(r), 32'h0);
      bus_rd(A_CNT, r);  check("R2 counter still idle", 32'(r), 32'h0);
   endtask

   task automatic t_config();
      logic [15:0] r;
      bus_wr(A_CFG, 16'h2210);
      bus_rd(A_CFG, r);  check("R4 first cfg write taken", 32'(r), 32'h2210);
      bus_rd(A_STAT, r); check("R4 lock after cfg write", 32'(r), 32'h4);
      bus_wr(A_CFG, 16'h1234);
      bus_rd(A_CFG, r);  check("R4 second cfg write ignored", 32'(r), 32'h2210);
      bus_wr(A_ACT, 16'h0000);
      bus_rd(A_ACT, r);  check("R4 act write ignored", 32'(r), 32'h01);
   endtask

   task automatic t_first_refresh();
      logic [15:0] r;
      bus_wr(A_KICK, 16'h0000);
      bus_wr(A_KICK, 16'h0000);
      bus_rd(A_KICK, r);
      bus_wr(A_ACT, 16'h0001);
      bus_wr(A_KICK, 16'h00FF);
      bus_rd(A_CNT, r);  check("R3 R6 refresh loads reload", 32'(r), 32'd32);
      bus_rd(A_STAT, r); check("R6 running", 32'(r), 32'hC);
      repeat (3) @(negedge clk);
      bus_rd(A_CNT, r);  check("R6 no tick before 4 clocks", 32'(r), 32'd32);
      @(negedge clk);
      bus_rd(A_CNT, r);  check("R6 tick after 4 clocks", 32'(r), 32'd31);
   endtask

   task automatic t_early();
      logic [15:0] r;
      bus_wr(A_KICK, 16'h0000);
      bus_wr(A_KICK, 16'h00FF);
      check("R8 early err pulse", 32'(err_o), 32'h1);
      check("R10 early reset request", 32'(rst_req_o), 32'h1);
      bus_rd(A_CNT, r);  check("R8 no reload on violation", 32'(r), 32'd31);
      bus_rd(A_STAT, r); check("R8 window sticky bit", 32'(r), 32'hE);
      @(negedge clk);
      check("R8 err one cycle", 32'(err_o), 32'h0);
   endtask

   task automatic t_in_window();
      logic [15:0] r;
      int e0;
      wait_cnt(16'd16, "R7 poll 16");
      e0 = err_cnt;
      bus_wr(A_KICK, 16'h0000);
      bus_wr(A_KICK, 16'h00FF);
      bus_rd(A_CNT, r); check("R7 in-window reload", 32'(r), 32'd32);
      repeat (2) @(negedge clk);
      check("R7 in-window no error", 32'(err_cnt - e0), 32'd0);
   endtask

   task automatic t_late_arm();
      logic [15:0] r;
      int e0;
      wait_cnt(16'd28, "R7 poll 28");
      e0 = err_cnt;
      bus_wr(A_KICK, 16'h0000);
      wait_cnt(16'd20, "R7 poll 20");
      bus_wr(A_KICK, 16'h00FF);
      bus_rd(A_CNT, r); check("R7 arm outside window still valid", 32'(r), 32'd32);
      repeat (2) @(negedge clk);
      check("R7 arm outside window no error", 32'(err_cnt - e0), 32'd0);
   endtask

   task automatic t_late_window();
      logic [15:0] r;
      wait_cnt(16'd5, "R8 poll 5");
      bus_wr(A_KICK, 16'h0000);
      bus_wr(A_KICK, 16'h00FF);
      check("R8 late err pulse", 32'(err_o), 32'h1);
      bus_rd(A_CNT, r); check("R8 late no reload", 32'(r <= 16'd5), 32'h1);
   endtask

   task automatic t_underflow();
      logic [15:0] r;
      int n, r0;
      @(negedge clk);
      wait_err(400, n);
      check("R9 underflow err", 32'(err_o), 32'h1);
      check("R10 underflow reset request", 32'(rst_req_o), 32'h1);
      bus_rd(A_CNT, r);  check("R9 reload after underflow", 32'(r), 32'd32);
      bus_rd(A_STAT, r); check("R9 underflow sticky bit", 32'(r[0]), 32'h1);
      r0 = req_cnt;
      @(negedge clk);
      wait_err(400, n);
      check("R9 underflow spacing", 32'(n + 1), 32'd132);
      check("R10 request count", 32'(req_cnt - r0), 32'd1);
   endtask

   task automatic t_sys_reset();
      logic [15:0] r;
      int e0;
      sys_rst_ni = 1'b0;
      @(negedge clk);
      sys_rst_ni = 1'b1;
      bus_rd(A_STAT, r); check("R5 sys reset clears sticky, keeps lock", 32'(r), 32'hC);
      bus_wr(A_CFG, 16'h0000);
      bus_rd(A_CFG, r);  check("R5 cfg still locked after sys reset", 32'(r), 32'h2210);
      wait_cnt(16'd20, "R5 poll 20");
      e0 = err_cnt;
      bus_wr(A_KICK, 16'h0000);
      sys_rst_ni = 1'b0;
      @(negedge clk);
      sys_rst_ni = 1'b1;
      bus_wr(A_KICK, 16'h00FF);
      bus_rd(A_CNT, r);  check("R5 pending key dropped by sys reset", 32'(r < 16'd21), 32'h1);
      check("R5 no error from dropped key", 32'(err_cnt - e0), 32'd0);
   endtask

   task automatic t_wd_reset_act();
      logic [15:0] r;
      int n, r0;
      wd_reset();
      bus_rd(A_CFG, r);  check("R5 wd reset restores cfg", 32'(r), 32'h33F3);
      bus_rd(A_STAT, r); check("R5 wd reset clears lock", 32'(r), 32'h0);
      bus_wr(A_ACT, 16'h0000);
      bus_rd(A_ACT, r);  check("R4 act write taken once", 32'(r), 32'h0);
      bus_wr(A_CFG, 16'h2210);
      bus_rd(A_CFG, r);  check("R4 act write locks cfg", 32'(r), 32'h33F3);
      bus_wr(A_KICK, 16'h0000);
      bus_wr(A_KICK, 16'h00FF);
      r0 = req_cnt;
      wait_err(20000, n);
      check("R9 default-config underflow", 32'(err_o), 32'h1);
      check("R10 request masked", 32'(req_cnt - r0), 32'd0);
   endtask

   task automatic t_refresh_locks();
      logic [15:0] r;
      wd_reset();
      bus_wr(A_KICK, 16'h0000);
      bus_wr(A_KICK, 16'h00FF);
      bus_rd(A_STAT, r); check("R4 refresh sets lock", 32'(r), 32'hC);
      bus_wr(A_CFG, 16'h2210);
      bus_rd(A_CFG, r);  check("R4 cfg locked by refresh", 32'(r), 32'h33F3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);
      t_reset();
      t_bad_keys();
      t_config();
      t_first_refresh();
      t_early();
      t_in_window();
      t_late_arm();
      t_late_window();
      t_underflow();
      t_sys_reset();
      t_wd_reset_act();
      t_refresh_locks();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule